// File: doc/BRIEF.md
# Context-Switch Duration Logger

This block records, cycle by cycle, how long each process held the processor between scheduler context switches. Software first issues a start command. This clears the interval timer and empties the log, and the timer then advances once per clock. Each time the scheduler writes the ID of the process it is switching to, the block stores one entry and restarts the timer. The entry holds the number of cycles since the previous switch (or since start) together with the new process ID.

The entries sit in an on-chip FIFO that maps onto block RAM. When the run is over, software polls a status word and drains the log through a data register. Each entry comes back as two 32-bit reads, duration first and then process ID, and this rebuilds the full timeline of switches. A stop command freezes logging. If the log fills, new entries are discarded and a sticky overflow bit records that the timeline is incomplete.

Top module: `ctxsw_logger`

## Requirements
- R1: After reset the block is stopped, the log is empty with a count of zero, the overflow bit is clear and `rdata` is zero.
- R2: Writing 1 to bit 0 of the control register (address 0) sets the running state, which is read back in bit 0 of the same register. It also empties the log, clears the overflow bit, restarts the timer and returns the data register to its duration half. Writing 1 to bit 1 alone clears the running state.
- R3: While running, the timer advances by one each clock. The duration stored in an entry equals the number of clock edges between the register write that last restarted the timer and the process ID write that creates the entry.
- R4: While running, a write to the process ID register (address 1) appends one entry of {duration, ID} and restarts the timer at the same edge. The ID is the low `PID_W` bits of `wdata`.
- R5: While stopped, a write to the process ID register adds no entry and leaves the log count unchanged.
- R6: The timer stops at 2^`TIMER_W`-1 and does not wrap. An entry taken after a longer interval reports 2^`TIMER_W`-1.
- R7: When the log already holds `DEPTH` entries, a further ID write is dropped, the stored entries stay intact and overflow (status bit 2) is set. The bit stays set until software writes 1 to status bit 2 or issues a start.
- R8: A read of the status register (address 2) returns empty in bit 0, full in bit 1, overflow in bit 2 and the entry count from bit 16 upward. Every register read appears on `rdata` one clock after `rd_en`.
- R9: Reads of the data register (address 3) alternate. The first returns the entry's duration zero-extended, the second returns its ID zero-extended and removes the entry. Entries leave in the order they were written.
- R10: A data register read while the log is empty returns zero and changes neither the log nor the half selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 control, 1 process ID, 2 status, 3 data |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered, valid the clock after `rd_en` |

## Verification
The bench records the edge of every write and derives each expected duration from those edges. A design that is off by one in the timer restart, or that stores the value after clearing instead of before, shows up in every entry. A run shortened by a narrow timer covers saturation, so a counter that wraps would report a tiny duration. Filling past the depth checks that the oldest entries survive and that the overflow bit sticks until it is cleared. A start issued between the two halves of an entry checks that the half selection resets, and a logger that kept the stale half would return the ID where the duration is expected. Reads of the data register while empty and ID writes while stopped must leave the count and the ordering untouched.

// File: rtl/ctxlog_pkg.sv
package ctxlog_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PID  = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_addr_e;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_STOP_BIT  = 1;
  localparam int ST_EMPTY_BIT   = 0;
  localparam int ST_FULL_BIT    = 1;
  localparam int ST_OVF_BIT     = 2;
  localparam int ST_CNT_LSB     = 16;
endpackage

// File: rtl/ctxlog_timer.sv
module ctxlog_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         restart,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (restart)
      count <= ONE;
    else if (run && count != MAXV)
      count <= count + ONE;
  end

  // R6
  timer_sat_chk: assert property (@(posedge clk) disable iff (rst)
    run && !restart && count == MAXV |=> count == MAXV);

  // R3
  timer_step_chk: assert property (@(posedge clk) disable iff (rst)
    run && !restart && count != MAXV |=> count == $past(count) + ONE);

  // R4
  timer_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> count == ONE);
endmodule

// File: rtl/ctxlog_fifo.sv
module ctxlog_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  input  logic             ovf_clr,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count,
  output logic             overflow
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp, rp_nxt;
  logic [WIDTH-1:0] raw_q, byp_d;
  logic             byp_hit;
  logic             push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CMAX);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  always_comb begin
    if (flush)
      rp_nxt = '0;
    else if (pop_ok)
      rp_nxt = (rp == LAST) ? '0 : rp + AW'(1);
    else
      rp_nxt = rp;
  end

  // storage and registered read port, block RAM style
  always_ff @(posedge clk) begin
    if (push_ok)
      mem[wp] <= wdata;
    raw_q <= mem[rp_nxt];
  end

  // read-during-write bypass kept outside the memory
  always_ff @(posedge clk) begin
    byp_hit <= push_ok && (wp == rp_nxt);
    byp_d   <= wdata;
  end

  assign head = byp_hit ? byp_d : raw_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      rp <= rp_nxt;
      if (push_ok)
        wp <= (wp == LAST) ? '0 : wp + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush)
      overflow <= 1'b0;
    else if (push && full)
      overflow <= 1'b1;
    else if (ovf_clr)
      overflow <= 1'b0;
  end

  // R7
  fifo_ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    push && full && !flush |=> overflow);

  // R7
  fifo_keep_full_chk: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop && !flush |=> count == $past(count));

  // R4
  fifo_push_chk: assert property (@(posedge clk) disable iff (rst)
    push && !full && !pop && !flush |=> count == $past(count) + CW'(1));

  // R9
  fifo_pop_chk: assert property (@(posedge clk) disable iff (rst)
    pop && !empty && !push && !flush |=> count == $past(count) - CW'(1));
endmodule

// File: rtl/ctxsw_logger.sv
module ctxsw_logger #(
  parameter int DATA_W  = 32,
  parameter int TIMER_W = 32,
  parameter int PID_W   = 32,
  parameter int DEPTH   = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import ctxlog_pkg::*;

  localparam int EW = TIMER_W + PID_W;
  localparam int CW = $clog2(DEPTH + 1);

  logic               running;
  logic               lo_sel;
  logic               start_cmd, stop_cmd, pid_wr, data_rd, pop, ovf_clr;
  logic [TIMER_W-1:0] tcount;
  logic [EW-1:0]      entry, head;
  logic               f_empty, f_full, f_ovf;
  logic [CW-1:0]      f_count;
  logic [DATA_W-1:0]  stat_word;

  assign start_cmd = wr_en && addr == REG_CTRL && wdata[CTRL_START_BIT];
  assign stop_cmd  = wr_en && addr == REG_CTRL && wdata[CTRL_STOP_BIT] && !wdata[CTRL_START_BIT];
  assign pid_wr    = wr_en && addr == REG_PID && running;
  assign ovf_clr   = wr_en && addr == REG_STAT && wdata[ST_OVF_BIT];
  assign data_rd   = rd_en && addr == REG_DATA && !f_empty;
  assign pop       = data_rd && lo_sel;
  assign entry     = {tcount, wdata[PID_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst)
      running <= 1'b0;
    else if (start_cmd)
      running <= 1'b1;
    else if (stop_cmd)
      running <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || start_cmd)
      lo_sel <= 1'b0;
    else if (data_rd)
      lo_sel <= !lo_sel;
  end

  ctxlog_timer #(.W(TIMER_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (running),
    .restart (start_cmd || pid_wr),
    .count   (tcount)
  );

  ctxlog_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .flush    (start_cmd),
    .push     (pid_wr),
    .wdata    (entry),
    .pop      (pop),
    .ovf_clr  (ovf_clr),
    .head     (head),
    .empty    (f_empty),
    .full     (f_full),
    .count    (f_count),
    .overflow (f_ovf)
  );

  always_comb begin
    stat_word                      = '0;
    stat_word[ST_EMPTY_BIT]        = f_empty;
    stat_word[ST_FULL_BIT]         = f_full;
    stat_word[ST_OVF_BIT]          = f_ovf;
    stat_word[ST_CNT_LSB +: CW]    = f_count;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en) begin
      case (addr)
        REG_CTRL: rdata <= DATA_W'(running);
        REG_STAT: rdata <= stat_word;
        REG_DATA: begin
          if (f_empty)
            rdata <= '0;
          else if (lo_sel)
            rdata <= DATA_W'(head[PID_W-1:0]);
          else
            rdata <= DATA_W'(head[EW-1:PID_W]);
        end
        default:  rdata <= '0;
      endcase
    end
  end

  // R5
  stop_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == REG_PID && !running |=> $stable(f_count));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == REG_DATA && f_empty |=> rdata == '0);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_cmd |=> running && f_empty && !f_ovf);
endmodule

// File: tb/ctxsw_logger_tb.sv
module ctxsw_logger_tb;
  localparam int DW  = 32;
  localparam int TW  = 12;
  localparam int PW  = 16;
  localparam int DEP = 8;
  localparam int TMAX = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, rd_en;
  logic [1:0]    addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_edge = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ctxsw_logger #(.DATA_W(DW), .TIMER_W(TW), .PID_W(PW), .DEPTH(DEP)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    last_edge = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic [DW-1:0] sat(input int v);
    return (v > TMAX) ? DW'(TMAX) : DW'(v);
  endfunction

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 rdata after reset", rdata, '0);
    reg_rd(2'd2, d); check("R1 status after reset", d, 32'h1);
    reg_rd(2'd0, d); check("R1 stopped after reset", d, 32'h0);
  endtask

  task automatic t_basic();
    logic [DW-1:0] d;
    int e_prev;
    int dur [3];
    logic [DW-1:0] ids [3];
    ids[0] = 32'h0A1; ids[1] = 32'h0B2; ids[2] = 32'hFFFF;
    reg_wr(2'd0, 32'h1);
    e_prev = last_edge;
    reg_rd(2'd0, d); check("R2 running after start", d, 32'h1);
    reg_rd(2'd2, d); check("R2 empty after start", d, 32'h1);
    repeat (3) @(negedge clk);
    reg_wr(2'd1, ids[0]); dur[0] = last_edge - e_prev; e_prev = last_edge;
    reg_wr(2'd1, ids[1]); dur[1] = last_edge - e_prev; e_prev = last_edge;
    repeat (10) @(negedge clk);
    reg_wr(2'd1, ids[2] | 32'hABCD0000); dur[2] = last_edge - e_prev;
    reg_rd(2'd2, d); check("R8 status with three entries", d, (32'd3 << 16));
    for (int i = 0; i < 3; i++) begin
      reg_rd(2'd3, d); check("R3 duration half", d, sat(dur[i]));
      reg_rd(2'd3, d); check("R4 R9 id half", d, ids[i]);
    end
    reg_rd(2'd2, d); check("R9 empty after drain", d, 32'h1);
  endtask

  task automatic t_stop();
    logic [DW-1:0] d;
    reg_wr(2'd0, 32'h2);
    reg_rd(2'd0, d); check("R2 stop clears running", d, 32'h0);
    reg_wr(2'd1, 32'h55);
    reg_rd(2'd2, d); check("R5 id write while stopped ignored", d, 32'h1);
    reg_rd(2'd3, d); check("R10 empty data read is zero", d, 32'h0);
    reg_rd(2'd2, d); check("R10 empty read leaves status", d, 32'h1);
  endtask

  task automatic t_sat();
    logic [DW-1:0] d;
    int e_prev, d2;
    reg_wr(2'd0, 32'h1);
    e_prev = last_edge;
    repeat (5000) @(negedge clk);
    reg_wr(2'd1, 32'h7);
    check("R6 interval exceeds timer range", DW'(last_edge - e_prev > TMAX), 32'h1);
    e_prev = last_edge;
    reg_wr(2'd1, 32'h8); d2 = last_edge - e_prev;
    reg_rd(2'd3, d); check("R6 saturated duration", d, DW'(TMAX));
    reg_rd(2'd3, d); check("R6 id after saturation", d, 32'h7);
    reg_rd(2'd3, d); check("R4 restart after saturation", d, sat(d2));
    reg_rd(2'd3, d); check("R4 second id", d, 32'h8);
  endtask

  task automatic t_overflow();
    logic [DW-1:0] d;
    int e_prev, d0;
    reg_wr(2'd0, 32'h1);
    e_prev = last_edge;
    for (int i = 0; i < 10; i++) begin
      reg_wr(2'd1, 32'h100 + i);
      if (i == 0) d0 = last_edge - e_prev;
    end
    reg_rd(2'd2, d); check("R7 R8 full with overflow", d, (32'd8 << 16) | 32'h6);
    for (int i = 0; i < 8; i++) begin
      reg_rd(2'd3, d);
      if (i == 0) check("R3 first duration after start", d, sat(d0));
      reg_rd(2'd3, d); check("R7 R9 kept entry order", d, 32'h100 + i);
    end
    reg_rd(2'd2, d); check("R7 overflow sticky after drain", d, 32'h5);
    reg_wr(2'd2, 32'h4);
    reg_rd(2'd2, d); check("R7 overflow cleared by write", d, 32'h1);
  endtask

  task automatic t_restart();
    logic [DW-1:0] d;
    int e_prev, d1;
    reg_wr(2'd1, 32'h31);
    reg_wr(2'd1, 32'h32);
    reg_rd(2'd3, d);
    reg_wr(2'd0, 32'h1);
    e_prev = last_edge;
    reg_rd(2'd2, d); check("R2 start empties log", d, 32'h1);
    repeat (4) @(negedge clk);
    reg_wr(2'd1, 32'h44); d1 = last_edge - e_prev;
    reg_rd(2'd3, d); check("R2 half select reset by start", d, sat(d1));
    reg_rd(2'd3, d); check("R2 id after restart", d, 32'h44);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_stop();
    t_sat();
    t_overflow();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule